// File: doc/BRIEF.md
# Serial Slave Byte Receiver with Holding Register

This block takes a byte stream from a serial master over a clock, data and active-low select wire set. It collects each character most significant bit first into a shift register and moves the finished character into a single holding register. A ready flag announces the new character to the consumer. An overrun flag records that a character arrived before the previous one was read.

The three serial wires come from another clock domain. Each passes through a synchronizer and is then handled in the system clock domain. A low level on select is enough to start reception; no falling edge is needed. The block has no receive timeout. A consumer reads the character by pulsing the read strobe, which clears the ready flag. It clears the overrun flag with a separate status-clear pulse.

Top module: `spi_slave_rx`

## Requirements
- R1: When the eighth bit of a character is sampled, the character is written to `rx_data` and `rx_ready` goes to 1 a few system clocks later.
- R2: Bits are sampled on the rising edge of `sclk_in` (parameter `SAMPLE_RISE`=1) while `ss_n_in` is low. The first bit sampled becomes bit 7 of `rx_data`.
- R3: If a character completes while `rx_ready` is 1, `rx_overrun` goes to 1 and the new character replaces the held one in `rx_data`.
- R4: `rx_overrun` returns to 0 only in the cycle after a `clr_status` pulse. `rd_strobe` leaves it unchanged. A new overrun in the same cycle as `clr_status` keeps it at 1.
- R5: A `rd_strobe` pulse with no completion in the same cycle clears `rx_ready` and leaves `rx_data` unchanged.
- R6: If `rd_strobe` and a completion fall in the same cycle, `rx_ready` stays 1.
- R7: If `ss_n_in` goes high before the eighth bit, the partial bits are discarded. `rx_data`, `rx_ready` and `rx_overrun` are not changed, and the next character starts again at bit 7.
- R8: Reception needs only a low level on `ss_n_in`. Characters that follow one another with select held low are all received. Any length of idle time with select low leaves the state unchanged.
- R9: After reset `rx_data` is 0x00, `rx_ready` is 0 and `rx_overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial bit clock from the master, asynchronous |
| mosi_in | input | 1 | Serial data from the master, asynchronous |
| ss_n_in | input | 1 | Active-low select, asynchronous |
| rd_strobe | input | 1 | One-cycle pulse: the holding register is read |
| clr_status | input | 1 | One-cycle pulse: clear the overrun flag |
| rx_data | output | 8 | Holding register contents |
| rx_ready | output | 1 | Unread character present |
| rx_overrun | output | 1 | A character arrived while one was unread |

## Verification
Some internal faults show up at the ports as a shifted or bit-reversed byte on `rx_data` as soon as the first character lands. These include a bit counter that is off by one, or one that does not restart after select is released. A flag fault shows within one character or one strobe. Examples are an overrun flag that clears on read, a ready flag that loses a same-cycle completion, or an aborted character that still raises ready. The bench holds the read strobe high across a whole completion and counts the cycles in which ready is high. That exposes an inverted collision priority.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned CNT_W  = $clog2(CHAR_W);
  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [CNT_W-1:0]  bitcnt_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
  import spi_rx_pkg::*;
#(
  parameter bit SAMPLE_RISE = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sclk_s,
  input  logic  mosi_s,
  input  logic  ss_n_s,
  output logic  done,
  output char_t char_out
);
  logic    sclk_q;
  logic    sample;
  bitcnt_t bit_cnt;
  char_t   shreg;
  char_t   next_char;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= ~SAMPLE_RISE;
    else     sclk_q <= sclk_s;
  end

  generate
    if (SAMPLE_RISE) begin : g_rise
      assign sample = sclk_s & ~sclk_q & ~ss_n_s;
    end else begin : g_fall
      assign sample = ~sclk_s & sclk_q & ~ss_n_s;
    end
  endgenerate

  assign next_char = {shreg[CHAR_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      done     <= 1'b0;
      char_out <= '0;
    end else begin
      done <= 1'b0;
      if (ss_n_s) begin
        bit_cnt <= '0;
      end else if (sample) begin
        shreg <= next_char;
        if (bit_cnt == bitcnt_t'(CHAR_W - 1)) begin
          bit_cnt  <= '0;
          done     <= 1'b1;
          char_out <= next_char;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R7
  ss_abort_chk: assert property (@(posedge clk) disable iff (rst)
    ss_n_s |=> (bit_cnt == '0) && !done);

  // R2
  done_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !$past(ss_n_s));
endmodule

// File: rtl/spi_rx_holding.sv
module spi_rx_holding
  import spi_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  done,
  input  char_t char_in,
  input  logic  rd_strobe,
  input  logic  clr_status,
  output char_t rx_data,
  output logic  rx_ready,
  output logic  rx_overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (done) begin
        rx_data  <= char_in;
        rx_ready <= 1'b1;
      end else if (rd_strobe) begin
        rx_ready <= 1'b0;
      end
      if (done && rx_ready)  rx_overrun <= 1'b1;
      else if (clr_status)   rx_overrun <= 1'b0;
    end
  end

  // R1
  load_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_ready && (rx_data == $past(char_in)));

  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rx_ready) |=> rx_overrun);

  // R4
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !clr_status) |=> rx_overrun);

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !done) |=> !rx_ready && $stable(rx_data));

  // R6
  rd_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && done) |=> rx_ready);
endmodule

// File: rtl/spi_slave_rx.sv
module spi_slave_rx
  import spi_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          SAMPLE_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              mosi_in,
  input  logic              ss_n_in,
  input  logic              rd_strobe,
  input  logic              clr_status,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_overrun
);
  localparam logic [2:0] SYNC_RST = {~SAMPLE_RISE, 1'b0, 1'b1};

  logic [2:0] sync_q;
  logic       done;
  char_t      char_w;

  spi_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_in, mosi_in, ss_n_in}),
    .q   (sync_q)
  );

  spi_rx_shifter #(.SAMPLE_RISE(SAMPLE_RISE)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sync_q[2]),
    .mosi_s   (sync_q[1]),
    .ss_n_s   (sync_q[0]),
    .done     (done),
    .char_out (char_w)
  );

  spi_rx_holding u_hold (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .char_in    (char_w),
    .rd_strobe  (rd_strobe),
    .clr_status (clr_status),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun)
  );
endmodule

// File: tb/spi_slave_rx_test.sv
module spi_slave_rx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1, rd = 1'b0, clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_ready, rx_overrun;
  int checks = 0, errors = 0;
  int rdy_cycles = 0;
  localparam int HALF = 8;

  always #2 clk = ~clk;

  spi_slave_rx uut (
    .clk(clk), .rst(rst), .sclk_in(sclk), .mosi_in(mosi), .ss_n_in(ss_n),
    .rd_strobe(rd), .clr_status(clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  always @(negedge clk) if (rx_ready) rdy_cycles++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = v[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(2 * HALF);
  endtask

  task automatic select_on();
    ss_n = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic select_off();
    ss_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic pulse(input bit do_rd, input bit do_clr);
    rd = do_rd; clr = do_clr;
    wait_clk(1);
    rd = 1'b0; clr = 1'b0;
    wait_clk(2);
  endtask

  task automatic t_reset();
    chk("R9 data", rx_data, 8'h00);
    chk("R9 ready", rx_ready, 0);
    chk("R9 overrun", rx_overrun, 0);
  endtask

  task automatic t_single();
    select_on();
    send_bits(8'hA5, 8);
    select_off();
    chk("R1 ready", rx_ready, 1);
    chk("R2 msb-first data", rx_data, 8'hA5);
    chk("R1 no overrun", rx_overrun, 0);
  endtask

  task automatic t_read();
    pulse(1'b1, 1'b0);
    chk("R5 ready cleared", rx_ready, 0);
    chk("R5 data kept", rx_data, 8'hA5);
  endtask

  task automatic t_overrun();
    select_on();
    send_bits(8'h3C, 8);
    send_bits(8'hC3, 8);
    select_off();
    chk("R3 newest data", rx_data, 8'hC3);
    chk("R3 overrun set", rx_overrun, 1);
    pulse(1'b1, 1'b0);
    chk("R4 read keeps overrun", rx_overrun, 1);
    chk("R5 ready cleared", rx_ready, 0);
    pulse(1'b0, 1'b1);
    chk("R4 clear", rx_overrun, 0);
  endtask

  task automatic t_abort();
    select_on();
    send_bits(8'hF0, 4);
    select_off();
    chk("R7 ready untouched", rx_ready, 0);
    chk("R7 data untouched", rx_data, 8'hC3);
    chk("R7 overrun untouched", rx_overrun, 0);
    select_on();
    send_bits(8'h81, 8);
    select_off();
    chk("R7 restart at bit 7", rx_data, 8'h81);
    pulse(1'b1, 1'b0);
  endtask

  task automatic t_level_idle();
    select_on();
    send_bits(8'h5A, 8);
    chk("R8 first byte", rx_data, 8'h5A);
    pulse(1'b1, 1'b0);
    wait_clk(3000);
    chk("R8 idle keeps ready low", rx_ready, 0);
    chk("R8 idle keeps data", rx_data, 8'h5A);
    send_bits(8'h96, 8);
    chk("R8 second byte", rx_data, 8'h96);
    chk("R8 second ready", rx_ready, 1);
    select_off();
    pulse(1'b1, 1'b0);
  endtask

  task automatic t_collide();
    rd = 1'b1;
    select_on();
    rdy_cycles = 0;
    send_bits(8'h4E, 8);
    rd = 1'b0;
    select_off();
    chk("R6 ready high one cycle", rdy_cycles, 1);
    chk("R6 data", rx_data, 8'h4E);
    chk("R6 no overrun", rx_overrun, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    t_single();
    t_read();
    t_overrun();
    t_abort();
    t_level_idle();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule